// File: doc/BRIEF.md
# Scan Block Result FIFO

This block holds finished touch-panel scan results until a host reads them. A scan produces a block of two, three or four 16-bit measurement words. The scan type picks the block size: X and Y; X, Y and Z1; or X, Y, Z1 and Z2. Words arrive one per cycle on the write side, and the final word of a block carries a completion flag. The block is made visible to the reader as one unit only when that flag arrives. If the block does not fit, or its length does not match the scan type, none of it is stored.

The host drains the store one byte at a time through a pop interface. Blocks come out in the order they were committed. Words within a block come out in arrival order, and each word gives its upper byte before its lower byte. An interrupt level rises when a block is committed and falls once the store has been read empty. A sticky overflow flag records any block that was refused for lack of space. A write to the configuration strobe empties everything, and so does any change of the autonomous/direct conversion mode input.

Reset is asynchronous and active low. The reset input is expected to be released synchronously to the clock by the surrounding logic.

Top module: `scan_block_fifo`

## Requirements
- R1: The store keeps at most 16 committed blocks and at most 64 words. A 17th block that arrives while 16 are held is not stored.
- R2: The expected block length comes from scan_mode as 0 → 2 words, 1 → 3 words, 2 or 3 → 4 words, sampled at the first word of a block. A block whose completion flag arrives on any other word count is discarded, and the overflow flag is not set.
- R3: rd_valid stays 0 while a block is still arriving. It becomes 1 after the clock edge that accepts the flagged final word of a correctly sized block.
- R4: irq is 0 after reset and rises at the edge that commits a block. It stays 1 while any byte is unread and falls after the pop that empties the store.
- R5: A block that starts while 16 blocks are held, or while fewer free words remain than its length, is discarded whole. The overflow flag is set at its final word and stays set through reads. Later blocks are accepted again once space is freed.
- R6: A one-cycle pulse on cfg_wr empties the store and abandons any partly received block. It also clears irq and overflow.
- R7: Any change of auto_mode, from 0 to 1 or from 1 to 0, clears everything exactly as R6 does.
- R8: rd_byte shows bits [15:8] of the oldest unread word. After one pop it shows bits [7:0] of the same word, and after the next pop it moves to the following word. Words come out in arrival order and blocks in commit order.
- R9: A pop while rd_valid is 0 has no effect. While rd_valid is 1, rd_byte holds its value until a pop or a clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_valid | input | 1 | A measurement word is presented this cycle |
| meas_word | input | 16 | Measurement word |
| meas_last | input | 1 | This word completes the current block |
| scan_mode | input | 2 | Scan type selecting the block length |
| cfg_wr | input | 1 | Configuration write strobe; clears the store |
| auto_mode | input | 1 | 1 = autonomous conversions, 0 = direct conversions |
| rd_pop | input | 1 | Consume the byte shown on rd_byte |
| rd_byte | output | 8 | Next byte to be read |
| rd_valid | output | 1 | At least one committed byte is unread |
| irq | output | 1 | Interrupt level for committed data |
| overflow | output | 1 | Sticky flag: a block was refused for lack of space |

## Verification
On every cycle the assertions check the following properties:
- data can only appear through a commit;
- any clear leaves the outputs empty;
- the overflow flag stays set until a clear;
- irq is high whenever data is readable;
- the word and block counts stay within their limits;
- the shown byte holds steady while no pop arrives.

Only the bench scenarios can show the actual byte values and their order across blocks of different sizes. They also show that badly sized and refused blocks leave no trace, that the 17th block is absent after draining, and that an abandoned partial block does not merge with the words that follow a clear.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int STG_W  = 3;   // holds a word count of up to four

  typedef enum logic [1:0] {
    SCAN_XY     = 2'd0,
    SCAN_XYZ1   = 2'd1,
    SCAN_ALL    = 2'd2,
    SCAN_ALL_B  = 2'd3
  } scan_kind_e;

  // Number of words a block of the given scan kind carries.
  function automatic logic [STG_W-1:0] block_words(input logic [1:0] kind);
    case (scan_kind_e'(kind))
      SCAN_XY:   block_words = 3'd2;
      SCAN_XYZ1: block_words = 3'd3;
      default:   block_words = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/sbf_store.sv
module sbf_store #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 17,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/sbf_stager.sv
module sbf_stager
  import sbf_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             meas_valid,
  input  logic             meas_last,
  input  logic [1:0]       scan_mode,
  input  logic [CW-1:0]    free_words,
  input  logic             blk_room,
  output logic             wr_en,
  output logic [STG_W-1:0] wr_off,
  output logic             wr_end,
  output logic             commit,
  output logic [STG_W-1:0] commit_len,
  output logic             ovf_evt
);

  logic [STG_W-1:0] cnt_q, cnt_d;
  logic [STG_W-1:0] len_q, len_d;
  logic             room_q, room_d;
  logic             bad_q, bad_d;

  logic             first;
  logic [STG_W-1:0] len_now;
  logic             room_now;
  logic             bad_now;
  logic             at_end;
  logic             take;

  always_comb begin
    first    = (cnt_q == '0);
    len_now  = first ? block_words(scan_mode) : len_q;
    room_now = first ? (blk_room && (free_words >= CW'(len_now))) : room_q;
    bad_now  = first ? 1'b0 : bad_q;
    at_end   = ((cnt_q + STG_W'(1)) == len_now);
    take     = meas_valid && !clr;

    wr_en      = take && room_now && !bad_now;
    wr_off     = cnt_q;
    wr_end     = at_end;
    commit     = take && meas_last && room_now && !bad_now && at_end;
    commit_len = len_now;
    ovf_evt    = take && meas_last && !room_now;
  end

  always_comb begin
    cnt_d  = cnt_q;
    len_d  = len_q;
    room_d = room_q;
    bad_d  = bad_q;
    if (clr) begin
      cnt_d = '0;
      bad_d = 1'b0;
    end else if (meas_valid) begin
      if (meas_last) begin
        cnt_d = '0;
        bad_d = 1'b0;
      end else begin
        len_d  = len_now;
        room_d = room_now;
        bad_d  = bad_now || at_end;
        if (!at_end) begin
          cnt_d = cnt_q + STG_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      len_q  <= '0;
      room_q <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      len_q  <= len_d;
      room_q <= room_d;
      bad_q  <= bad_d;
    end
  end

endmodule

// File: rtl/sbf_byte_reader.sv
module sbf_byte_reader
  import sbf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              pop_ok,
  input  logic [WORD_W-1:0] head_word,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              word_done
);

  logic lo_q, lo_d;

  always_comb begin
    lo_d = lo_q;
    if (clr) begin
      lo_d = 1'b0;
    end else if (pop_ok) begin
      lo_d = !lo_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= 1'b0;
    end else begin
      lo_q <= lo_d;
    end
  end

  assign rd_byte   = lo_q ? head_word[BYTE_W-1:0] : head_word[WORD_W-1:BYTE_W];
  assign word_done = pop_ok && lo_q;

endmodule

// File: rtl/scan_block_fifo.sv
module scan_block_fifo
  import sbf_pkg::*;
#(
  parameter int DEPTH_WORDS = 64,
  parameter int MAX_BLOCKS  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              meas_valid,
  input  logic [WORD_W-1:0] meas_word,
  input  logic              meas_last,
  input  logic [1:0]        scan_mode,
  input  logic              cfg_wr,
  input  logic              auto_mode,
  input  logic              rd_pop,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              rd_valid,
  output logic              irq,
  output logic              overflow
);

  localparam int AW = $clog2(DEPTH_WORDS);
  localparam int CW = AW + 1;
  localparam int BW = $clog2(MAX_BLOCKS + 1);
  localparam int EW = WORD_W + 1;   // stored word plus block-end marker

  logic [AW-1:0] head_q, head_d, tail_q, tail_d;
  logic [CW-1:0] words_q, words_d;
  logic [BW-1:0] blks_q, blks_d;
  logic          irq_q, irq_d;
  logic          ovf_q, ovf_d;
  logic          auto_q;

  logic             clr;
  logic             pop_ok;
  logic [CW-1:0]    free_words;
  logic             blk_room;
  logic             wr_en, wr_end, commit, ovf_evt, word_done;
  logic [STG_W-1:0] wr_off, commit_len;
  logic [EW-1:0]    head_entry;

  assign clr        = cfg_wr || (auto_mode != auto_q);
  assign rd_valid   = (words_q != '0);
  assign pop_ok     = rd_pop && rd_valid && !clr;
  assign free_words = CW'(DEPTH_WORDS) - words_q;
  assign blk_room   = (blks_q < BW'(MAX_BLOCKS));

  sbf_stager #(.CW(CW)) u_stager (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .meas_valid (meas_valid),
    .meas_last  (meas_last),
    .scan_mode  (scan_mode),
    .free_words (free_words),
    .blk_room   (blk_room),
    .wr_en      (wr_en),
    .wr_off     (wr_off),
    .wr_end     (wr_end),
    .commit     (commit),
    .commit_len (commit_len),
    .ovf_evt    (ovf_evt)
  );

  sbf_store #(.DEPTH(DEPTH_WORDS), .WIDTH(EW)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (tail_q + AW'(wr_off)),
    .wr_data ({wr_end, meas_word}),
    .rd_addr (head_q),
    .rd_data (head_entry)
  );

  sbf_byte_reader u_reader (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .pop_ok    (pop_ok),
    .head_word (head_entry[WORD_W-1:0]),
    .rd_byte   (rd_byte),
    .word_done (word_done)
  );

  always_comb begin
    head_d  = head_q;
    tail_d  = tail_q;
    words_d = words_q;
    blks_d  = blks_q;
    irq_d   = irq_q;
    ovf_d   = ovf_q;
    if (clr) begin
      head_d  = '0;
      tail_d  = '0;
      words_d = '0;
      blks_d  = '0;
      irq_d   = 1'b0;
      ovf_d   = 1'b0;
    end else begin
      if (commit) begin
        tail_d  = tail_q + AW'(commit_len);
        words_d = words_d + CW'(commit_len);
        blks_d  = blks_d + BW'(1);
        irq_d   = 1'b1;
      end else if (word_done && (words_q == CW'(1))) begin
        irq_d = 1'b0;
      end
      if (word_done) begin
        head_d  = head_q + AW'(1);
        words_d = words_d - CW'(1);
        if (head_entry[WORD_W]) begin
          blks_d = blks_d - BW'(1);
        end
      end
      if (ovf_evt) begin
        ovf_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      words_q <= '0;
      blks_q  <= '0;
      irq_q   <= 1'b0;
      ovf_q   <= 1'b0;
      auto_q  <= 1'b0;
    end else begin
      head_q  <= head_d;
      tail_q  <= tail_d;
      words_q <= words_d;
      blks_q  <= blks_d;
      irq_q   <= irq_d;
      ovf_q   <= ovf_d;
      auto_q  <= auto_mode;
    end
  end

  assign irq      = irq_q;
  assign overflow = ovf_q;

endmodule

// File: rtl/sbf_checker.sv
module sbf_checker #(
  parameter int DEPTH_WORDS = 64,
  parameter int MAX_BLOCKS  = 16,
  parameter int CW          = 7,
  parameter int BW          = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          commit,
  input logic          rd_pop,
  input logic [7:0]    rd_byte,
  input logic          rd_valid,
  input logic          irq,
  input logic          overflow,
  input logic [CW-1:0] words,
  input logic [BW-1:0] blks
);

  // R1: occupancy never exceeds either limit
  a_r1_within_limits: assert property (@(posedge clk) disable iff (!rst_n)
    (words <= CW'(DEPTH_WORDS)) && (blks <= BW'(MAX_BLOCKS)));

  // R3: data becomes readable only through a commit
  a_r3_no_early_data: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid && !commit) |=> !rd_valid);

  // R4: the interrupt is up whenever data can be read
  a_r4_irq_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> irq);

  // R5: overflow holds until a clear
  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clr) |=> overflow);

  // R6 and R7: any clear leaves nothing behind
  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!rd_valid && !irq && !overflow));

  // R9: the shown byte holds without a pop
  a_r9_byte_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_pop && !clr) |=> $stable(rd_byte));

endmodule

bind scan_block_fifo sbf_checker #(
  .DEPTH_WORDS (DEPTH_WORDS),
  .MAX_BLOCKS  (MAX_BLOCKS),
  .CW          (CW),
  .BW          (BW)
) u_sbf_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .clr      (clr),
  .commit   (commit),
  .rd_pop   (rd_pop),
  .rd_byte  (rd_byte),
  .rd_valid (rd_valid),
  .irq      (irq),
  .overflow (overflow),
  .words    (words_q),
  .blks     (blks_q)
);

// File: tb/scan_block_fifo_test.sv
module scan_block_fifo_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        meas_valid;
  logic [15:0] meas_word;
  logic        meas_last;
  logic [1:0]  scan_mode;
  logic        cfg_wr;
  logic        auto_mode;
  logic        rd_pop;
  logic [7:0]  rd_byte;
  logic        rd_valid;
  logic        irq;
  logic        overflow;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  scan_block_fifo uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .meas_valid (meas_valid),
    .meas_word  (meas_word),
    .meas_last  (meas_last),
    .scan_mode  (scan_mode),
    .cfg_wr     (cfg_wr),
    .auto_mode  (auto_mode),
    .rd_pop     (rd_pop),
    .rd_byte    (rd_byte),
    .rd_valid   (rd_valid),
    .irq        (irq),
    .overflow   (overflow)
  );

  function automatic logic [15:0] wv(input int id, input int idx);
    return {8'(8'h10 + id), 8'(8'hC0 + idx)};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic send_word(input logic [1:0] mode, input logic [15:0] w, input logic last);
    meas_valid = 1'b1;
    meas_word  = w;
    meas_last  = last;
    scan_mode  = mode;
    @(negedge clk);
    meas_valid = 1'b0;
    meas_last  = 1'b0;
  endtask

  task automatic send_block(input logic [1:0] mode, input int id, input int n);
    for (int i = 0; i < n; i++) send_word(mode, wv(id, i), i == n - 1);
  endtask

  task automatic pop_byte(output logic [7:0] b);
    b = rd_byte;
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  task automatic read_block(input string req, input int id, input int n);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      pop_byte(b);
      check(req, {8'h00, b}, {8'h00, wv(id, i)[15:8]});
      pop_byte(b);
      check(req, {8'h00, b}, {8'h00, wv(id, i)[7:0]});
    end
  endtask

  task automatic pulse_cfg();
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic t_reset();
    check("R3 reset rd_valid", {15'd0, rd_valid}, 16'd0);
    check("R4 reset irq", {15'd0, irq}, 16'd0);
    check("R5 reset overflow", {15'd0, overflow}, 16'd0);
  endtask

  task automatic t_basic();
    logic [7:0] b;
    send_word(2'd0, wv(1, 0), 1'b0);
    check("R3 partial block hidden", {15'd0, rd_valid}, 16'd0);
    check("R4 no irq before commit", {15'd0, irq}, 16'd0);
    send_word(2'd0, wv(1, 1), 1'b1);
    check("R3 visible after commit", {15'd0, rd_valid}, 16'd1);
    check("R4 irq at commit", {15'd0, irq}, 16'd1);
    pop_byte(b);
    check("R8 first byte is upper", {8'h00, b}, {8'h00, wv(1, 0)[15:8]});
    check("R4 irq held mid-read", {15'd0, irq}, 16'd1);
    pop_byte(b);
    check("R8 second byte is lower", {8'h00, b}, {8'h00, wv(1, 0)[7:0]});
    read_block("R8 basic tail", 1, 0);
    pop_byte(b);
    check("R8 next word upper", {8'h00, b}, {8'h00, wv(1, 1)[15:8]});
    pop_byte(b);
    check("R8 next word lower", {8'h00, b}, {8'h00, wv(1, 1)[7:0]});
    check("R4 irq drops when empty", {15'd0, irq}, 16'd0);
    check("R3 empty after read", {15'd0, rd_valid}, 16'd0);
  endtask

  task automatic t_modes();
    send_block(2'd1, 2, 3);
    send_block(2'd2, 3, 4);
    send_block(2'd3, 4, 4);
    read_block("R2 three-word block", 2, 3);
    read_block("R2 four-word block", 3, 4);
    read_block("R2 mode 3 four words", 4, 4);
    check("R2 all sizes drained", {15'd0, rd_valid}, 16'd0);
  endtask

  task automatic t_badlen();
    send_block(2'd0, 5, 3);
    send_block(2'd2, 6, 2);
    send_block(2'd1, 7, 1);
    check("R2 bad lengths dropped", {15'd0, rd_valid}, 16'd0);
    check("R2 no overflow on bad length", {15'd0, overflow}, 16'd0);
    send_block(2'd0, 8, 2);
    read_block("R2 recovery block", 8, 2);
  endtask

  task automatic t_overflow();
    for (int k = 0; k < 16; k++) send_block(2'd2, 32 + k, 4);
    check("R1 sixteen blocks fit", {15'd0, overflow}, 16'd0);
    send_block(2'd2, 64, 4);
    check("R5 overflow set", {15'd0, overflow}, 16'd1);
    read_block("R1 first block after overflow", 32, 4);
    check("R5 read keeps overflow", {15'd0, overflow}, 16'd1);
    send_block(2'd2, 80, 4);
    for (int k = 1; k < 16; k++) read_block("R1 stored block order", 32 + k, 4);
    read_block("R5 block accepted after space", 80, 4);
    check("R1 refused block absent", {15'd0, rd_valid}, 16'd0);
    check("R5 overflow still set", {15'd0, overflow}, 16'd1);
    pulse_cfg();
    check("R6 clear drops overflow", {15'd0, overflow}, 16'd0);
  endtask

  task automatic t_clear();
    send_block(2'd0, 96, 2);
    send_word(2'd0, wv(97, 0), 1'b0);
    pulse_cfg();
    check("R6 clear empties", {15'd0, rd_valid}, 16'd0);
    check("R6 clear drops irq", {15'd0, irq}, 16'd0);
    send_word(2'd0, wv(97, 1), 1'b1);
    check("R6 partial block abandoned", {15'd0, rd_valid}, 16'd0);
  endtask

  task automatic t_mode_switch();
    send_block(2'd0, 100, 2);
    auto_mode = 1'b1;
    @(negedge clk);
    check("R7 to autonomous clears", {15'd0, rd_valid}, 16'd0);
    check("R7 irq cleared", {15'd0, irq}, 16'd0);
    send_block(2'd0, 101, 2);
    check("R7 data kept while mode steady", {15'd0, rd_valid}, 16'd1);
    auto_mode = 1'b0;
    @(negedge clk);
    check("R7 to direct clears", {15'd0, rd_valid}, 16'd0);
  endtask

  task automatic t_pop_empty();
    logic [7:0] b;
    logic [7:0] b2;
    for (int i = 0; i < 3; i++) pop_byte(b);
    send_block(2'd0, 110, 2);
    b = rd_byte;
    @(negedge clk);
    @(negedge clk);
    b2 = rd_byte;
    check("R9 byte holds without pop", {8'h00, b2}, {8'h00, b});
    read_block("R9 empty pops ignored", 110, 2);
  endtask

  initial begin
    rst_n = 1'b0;
    meas_valid = 1'b0;
    meas_word = '0;
    meas_last = 1'b0;
    scan_mode = 2'd0;
    cfg_wr = 1'b0;
    auto_mode = 1'b0;
    rd_pop = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_modes();
    t_badlen();
    t_overflow();
    t_clear();
    t_mode_switch();
    t_pop_empty();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule